// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator with Dead Time

This block drives the six transistors of a two-level three-phase inverter bridge. A triangular carrier counts up from zero to a programmed period and back down. Each phase compares the carrier with its own duty value and commands its high-side switch on while the carrier is below that value. The complementary low-side command is the inverse. Both commands then pass through a per-leg dead-time stage. That stage holds off every turn-on for a programmed number of clocks, so the two switches of a leg are never on together.

An ADC sampling trigger is produced once per carrier cycle, a programmed number of clocks after the carrier's zero point. Period, duty values, dead time and trigger delay are all captured only at the zero point, so a carrier cycle never sees a half-applied update. A mode pin selects the gate polarity. In one mode all six gates are active high, for a bridge built only from N-channel devices. In the other mode the high-side gates are active low, for a bridge with P-channel high sides.

Top module: `tri_phase_pwm`

## Requirements
- R1: The carrier runs 0,1,…,P,P−1,…,1 and repeats, so one carrier cycle lasts 2P clocks for a period value P ≥ 1. The cycle in which the carrier is 0 is the zero point.
- R2: In no cycle are the high-side and low-side switches of the same leg both active.
- R3: A phase's high side is commanded on while carrier < compare value c. For 1 ≤ c ≤ P this gives a contiguous window of 2c−1 clocks per carrier cycle, centred on the zero point. c = 0 commands the low side for the whole cycle, and c > P commands the high side for the whole cycle.
- R4: Each gate output is registered. Its turn-off follows its command one clock later. Its turn-on is additionally delayed by the dead-time value D. A commanded window of L clocks therefore gives max(L−D,0) active clocks, and after a high side turns off the low side stays off for exactly D clocks.
- R5: The ADC trigger is a single-clock pulse in the cycle 1+Y clocks after the zero point, where Y is the delay value. With Y ≥ 2P no pulse is issued in that carrier cycle. A phase with c = 1 and D = 0 turns its high side on 1 clock after the zero point, which is the same cycle as the trigger when Y = 0.
- R6: Period, compare, dead-time and delay inputs are captured only in the zero-point cycle and act from the next cycle on. Changes at any other time have no effect on the outputs until the next zero point.
- R7: With the mode pin at 0, all six gate outputs are active high. With the mode pin at 1, the three high-side outputs are active low and the low-side outputs remain active high.
- R8: While reset is asserted, every gate output sits at its inactive level for the current mode and the ADC trigger is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periodIn | input | CNT_W | Carrier peak value P (≥ 1) |
| cmpA | input | CNT_W | Duty compare value, phase A |
| cmpB | input | CNT_W | Duty compare value, phase B |
| cmpC | input | CNT_W | Duty compare value, phase C |
| deadIn | input | DT_W | Dead time in clocks |
| delayIn | input | DLY_W | ADC trigger delay in clocks after the zero point |
| pMode | input | 1 | 0: all gates active high; 1: high-side gates active low |
| gateHi | output | 3 | High-side gate drives, bit 0 = phase A, bit 2 = phase C |
| gateLo | output | 3 | Low-side gate drives, bit 0 = phase A, bit 2 = phase C |
| adcTrig | output | 1 | One-clock ADC sampling pulse |

## Verification
The ADC trigger and the zero-point reload can fall in the same cycle. This happens when the delay equals 2P−1: the pulse is raised in the very cycle in which the next period's settings are captured. The bench runs such a configuration and requires exactly one pulse in every 2P-clock window, neither lost nor doubled. With a delay of exactly 2P, it requires no pulse at all. A second coincidence also gets its own check: a delay of 0 and a phase with compare value 1 must pulse the trigger and raise that phase's high side in the same clock.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // strobes from the carrier control to the gate datapath
  typedef struct packed {
    logic load;   // zero point: capture new settings
  } pwmStrobe_t;
endpackage

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [DLY_W-1:0] delayIn,
  output logic [CNT_W-1:0] carrier,
  output pwmStrobe_t       strobe,
  output logic             adcTrig
);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, perAct;
  logic [DLY_W-1:0] dlyCnt;
  logic             dirUp, armed, trigQ;
  logic             zeroPt;

  assign zeroPt      = (cnt == '0);
  assign carrier     = cnt;
  assign strobe.load = zeroPt;
  assign adcTrig     = trigQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      perAct <= '0;
      dirUp  <= 1'b1;
      dlyCnt <= '0;
      armed  <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      trigQ <= 1'b0;
      if (zeroPt) begin
        perAct <= periodIn;
        cnt    <= (periodIn == '0) ? '0 : CNT_ONE;
        dirUp  <= 1'b1;
        if (delayIn == '0) begin
          trigQ <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed  <= 1'b1;
          dlyCnt <= delayIn;
        end
      end else begin
        if (dirUp) begin
          if (cnt >= perAct) begin
            cnt   <= cnt - CNT_ONE;
            dirUp <= 1'b0;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end else begin
          cnt <= cnt - CNT_ONE;
        end
        if (armed) begin
          if (dlyCnt == DLY_ONE) begin
            trigQ <= 1'b1;
            armed <= 1'b0;
          end else begin
            dlyCnt <= dlyCnt - DLY_ONE;
          end
        end
      end
    end
  end

  // R1: carrier never leaves the range 0..P
  p_carrier_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= perAct);

  // R6: period only changes at the zero point
  p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !zeroPt |=> $stable(perAct));
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] carrier,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [DT_W-1:0]  deadVal,
  output logic             hiOn,
  output logic             loOn
);
  localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

  logic            cmdHi;
  logic [DT_W-1:0] hiWait, loWait;

  assign cmdHi = (carrier < cmpVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiOn   <= 1'b0;
      loOn   <= 1'b0;
      hiWait <= '0;
      loWait <= '0;
    end else begin
      if (!cmdHi) begin
        hiOn   <= 1'b0;
        hiWait <= '0;
      end else if (hiWait >= deadVal) begin
        hiOn <= 1'b1;
      end else begin
        hiWait <= hiWait + DT_ONE;
      end
      if (cmdHi) begin
        loOn   <= 1'b0;
        loWait <= '0;
      end else if (loWait >= deadVal) begin
        loOn <= 1'b1;
      end else begin
        loWait <= loWait + DT_ONE;
      end
    end
  end

  // R2: the two switches of a leg are never on together
  p_leg_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiOn && loOn));
endmodule

// File: rtl/pwm3_gates.sv
module pwm3_gates
  import pwm3_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DT_W   = 6,
  parameter int PHASES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CNT_W-1:0]              carrier,
  input  pwmStrobe_t                    strobe,
  input  logic [PHASES-1:0][CNT_W-1:0]  cmpIn,
  input  logic [DT_W-1:0]               deadIn,
  input  logic                          pMode,
  output logic [PHASES-1:0]             gateHi,
  output logic [PHASES-1:0]             gateLo
);
  logic [PHASES-1:0][CNT_W-1:0] cmpAct;
  logic [DT_W-1:0]              deadAct;
  logic [PHASES-1:0]            hiOn, loOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpAct  <= '0;
      deadAct <= '0;
    end else if (strobe.load) begin
      cmpAct  <= cmpIn;
      deadAct <= deadIn;
    end
  end

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_leg
    pwm3_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .carrier (carrier),
      .cmpVal  (cmpAct[ph]),
      .deadVal (deadAct),
      .hiOn    (hiOn[ph]),
      .loOn    (loOn[ph])
    );
  end

  // polarity selection: P-channel high sides are driven active low
  always_comb begin
    gateHi = pMode ? ~hiOn : hiOn;
    gateLo = loOn;
  end

  // R6: compare and dead-time settings move only on the load strobe
  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(cmpAct));
  p_dead_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(deadAct));
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6,
  parameter int DLY_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [CNT_W-1:0] cmpC,
  input  logic [DT_W-1:0]  deadIn,
  input  logic [DLY_W-1:0] delayIn,
  input  logic             pMode,
  output logic [2:0]       gateHi,
  output logic [2:0]       gateLo,
  output logic             adcTrig
);
  localparam int PHASES = 3;

  logic [CNT_W-1:0]             carrier;
  pwmStrobe_t                   strobe;
  logic [PHASES-1:0][CNT_W-1:0] cmpBus;

  assign cmpBus = {cmpC, cmpB, cmpA};

  pwm3_ctrl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .periodIn (periodIn),
    .delayIn  (delayIn),
    .carrier  (carrier),
    .strobe   (strobe),
    .adcTrig  (adcTrig)
  );

  pwm3_gates #(.CNT_W(CNT_W), .DT_W(DT_W), .PHASES(PHASES)) u_gates (
    .clk     (clk),
    .rst_n   (rst_n),
    .carrier (carrier),
    .strobe  (strobe),
    .cmpIn   (cmpBus),
    .deadIn  (deadIn),
    .pMode   (pMode),
    .gateHi  (gateHi),
    .gateLo  (gateLo)
  );
endmodule

// File: tb/tri_phase_pwm_test.sv
`timescale 1ns/1ps
module tri_phase_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] periodIn = 8'd10, cmpA = 8'd0, cmpB = 8'd0, cmpC = 8'd0;
  logic [5:0] deadIn = 6'd0;
  logic [8:0] delayIn = 9'd0;
  logic       pMode = 1'b0;
  logic [2:0] gateHi, gateLo;
  logic       adcTrig;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_phase_pwm uut (
    .clk(clk), .rst_n(rst_n), .periodIn(periodIn), .cmpA(cmpA), .cmpB(cmpB),
    .cmpC(cmpC), .deadIn(deadIn), .delayIn(delayIn), .pMode(pMode),
    .gateHi(gateHi), .gateLo(gateLo), .adcTrig(adcTrig)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] hiAct();
    return pMode ? ~gateHi : gateHi;
  endfunction

  // active clocks per carrier cycle (R3, R4)
  function automatic int expHi(int p, int c, int d);
    int l;
    if (c == 0) return 0;
    if (c > p) return 2 * p;
    l = 2 * c - 1;
    return (l > d) ? l - d : 0;
  endfunction
  function automatic int expLo(int p, int c, int d);
    int l;
    if (c == 0) return 2 * p;
    if (c > p) return 0;
    l = 2 * p + 1 - 2 * c;
    return (l > d) ? l - d : 0;
  endfunction

  task automatic setCfg(int p, int a, int b, int c, int d, int y, int m);
    periodIn = 8'(p); cmpA = 8'(a); cmpB = 8'(b); cmpC = 8'(c);
    deadIn = 6'(d); delayIn = 9'(y); pMode = 1'(m);
  endtask

  // P, cmpA, cmpB, cmpC, dead, delay, mode, expected triggers per cycle
  localparam int NVEC = 6;
  localparam int VEC [NVEC][8] = '{
    '{10, 5,  3,  8, 2,  4, 0, 1},
    '{10, 0, 11,  1, 0,  0, 1, 1},
    '{16, 2,  2,  2, 4, 31, 0, 1},
    '{ 8, 4,  6,  2, 3, 16, 0, 0},
    '{12, 12, 6,  7, 5,  3, 1, 1},
    '{ 1, 1,  0,  2, 0,  0, 0, 1}
  };

  initial begin
    // R8: reset levels in both modes
    tick(2);
    check("R8 hi mode0", int'(gateHi), 0);
    check("R8 lo mode0", int'(gateLo), 0);
    check("R8 trig", int'(adcTrig), 0);
    pMode = 1'b1;
    tick(1);
    check("R8/R7 hi mode1", int'(gateHi), 7);
    check("R8 lo mode1", int'(gateLo), 0);
    pMode = 1'b0;
    rst_n = 1'b1;

    // table walk: R1, R2, R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      int p, hiCnt[3], loCnt[3], trigs, overlap;
      int cv[3];
      p = VEC[v][0];
      cv[0] = VEC[v][1]; cv[1] = VEC[v][2]; cv[2] = VEC[v][3];
      setCfg(p, cv[0], cv[1], cv[2], VEC[v][4], VEC[v][5], VEC[v][6]);
      tick(200);
      trigs = 0; overlap = 0;
      for (int k = 0; k < 3; k++) begin hiCnt[k] = 0; loCnt[k] = 0; end
      for (int t = 0; t < 2 * p; t++) begin
        logic [2:0] h;
        h = hiAct();
        for (int k = 0; k < 3; k++) begin
          if (h[k]) hiCnt[k]++;
          if (gateLo[k]) loCnt[k]++;
        end
        if ((h & gateLo) != 3'b000) overlap++;
        if (adcTrig) trigs++;
        tick(1);
      end
      for (int k = 0; k < 3; k++) begin
        check($sformatf("R3/R4/R7 vec%0d hi%0d", v, k), hiCnt[k], expHi(p, cv[k], VEC[v][4]));
        check($sformatf("R3/R4 vec%0d lo%0d", v, k), loCnt[k], expLo(p, cv[k], VEC[v][4]));
      end
      check($sformatf("R2 vec%0d overlap", v), overlap, 0);
      check($sformatf("R5/R1 vec%0d trig count", v), trigs, VEC[v][7]);
    end

    // R4: off-gap between high-side turn-off and low-side turn-on
    begin
      int gap, guard;
      setCfg(10, 5, 0, 1, 3, 0, 0);
      tick(100);
      guard = 0;
      while (!hiAct()[0] && guard < 100) begin tick(1); guard++; end
      while (hiAct()[0] && guard < 200) begin tick(1); guard++; end
      gap = 0;
      while (!gateLo[0] && gap < 50) begin gap++; tick(1); end
      check("R4 dead gap", gap, 3);
    end

    // R5: trigger offset from zero point, and coincidence with delay 0
    begin
      int n, guard;
      setCfg(10, 0, 0, 1, 0, 5, 0);
      tick(100);
      guard = 0;
      while (!hiAct()[2] && guard < 100) begin tick(1); guard++; end
      n = 0;
      do begin tick(1); n++; end while (!adcTrig && n < 50);
      check("R5 trigger delay", n, 5);
      delayIn = 9'd0;
      tick(100);
      guard = 0;
      while (!hiAct()[2] && guard < 100) begin tick(1); guard++; end
      check("R5 trig with zero delay", int'(adcTrig), 1);
    end

    // R6: compare change mid-cycle is held until the next zero point
    begin
      int early, guard;
      setCfg(10, 0, 0, 1, 0, 0, 0);
      tick(100);
      guard = 0;
      while (!hiAct()[2] && guard < 100) begin tick(1); guard++; end
      cmpA = 8'd11;
      early = 0;
      for (int t = 0; t < 20; t++) begin
        tick(1);
        if (hiAct()[0]) early++;
      end
      check("R6 hold until zero point", early, 0);
      tick(1);
      check("R6 applied after zero point", int'(hiAct()[0]), 1);
    end

    // R7: mode 1 keeps low side active high while high side inverts
    begin
      setCfg(10, 11, 0, 0, 0, 0, 1);
      tick(100);
      check("R7 mode1 hi pins", int'(gateHi), 3'b110);
      check("R7 mode1 lo pins", int'(gateLo), 3'b110);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule